// File: doc/BRIEF.md
# PPM Pulse Interval Classifier

This block times the spacing between pulses on a pulse-position-modulated input and sorts each spacing into one of three bands: a short band that stands for a data zero, a longer band that stands for a data one, and a still longer band that separates words. It is meant to sit behind an analog front end. It feeds a word assembler that collects bits and acts on word separators.

The input idles low and pulses high. It passes through a two-flop synchronizer, and a pulse counts on its rising edge. A prescaler divides the clock by `PRESCALE`, and an interval counter advances once per prescaled tick. Pulses that arrive during a blanking period after the last accepted pulse are dropped, and they leave the counter running. An accepted pulse produces its classification strobe and then clears the counter and the prescaler. If no pulse arrives before the counter passes `GAP_MAX`, the block raises a single timeout strobe and holds the counter saturated. The next pulse then only restarts timing and classifies nothing. All window limits are parameters in prescaled counts, so every window scales with the clock frequency.

The outputs are single-cycle valid strobes with no ready signal. Pulse events cannot be held back, so the consumer must take each strobe in the cycle it appears.

Top module: `ppm_interval_classifier`

## Requirements
- R1: After reset all strobes are low and the counter is saturated, so the first pulse after reset produces no strobe.
- R2: A pulse detected while the count is below `BLANK` produces no strobe and does not clear the counter, so the next interval is still measured from the last accepted pulse.
- R3: A pulse detected with a count from `BLANK` to `ONE_MIN-1` gives `bit_vld`=1 with `bit_val`=0 for one cycle.
- R4: A pulse detected with a count from `ONE_MIN` to `GAP_MIN-1` gives `bit_vld`=1 with `bit_val`=1 for one cycle.
- R5: A pulse detected with a count from `GAP_MIN` to `GAP_MAX` gives `word_gap`=1 for one cycle.
- R6: When a tick would carry the count past `GAP_MAX` with no pulse present, `ivl_err` pulses once and the count saturates. The next pulse then only restarts timing and produces no strobe.
- R7: After an accepted pulse the count restarts at 0 and advances once every `PRESCALE` clocks. A pulse detected that many clocks after the clear therefore sees a count of (clocks-1)/`PRESCALE`, rounded down.
- R8: If a pulse is detected in the same cycle as the tick that would cause a timeout, the pulse wins. The interval is a word gap and no `ivl_err` is raised.
- R9: A strobe appears 3 clocks after the input rises. An input held high for many clocks counts as one pulse.
- R10: At most one of `bit_vld`, `word_gap` and `ivl_err` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously and is released in step with the clock |
| ppm_in | input | 1 | PPM pulse input, idle low |
| bit_vld | output | 1 | One-cycle strobe for a data-bit interval |
| bit_val | output | 1 | Bit value, meaningful while `bit_vld` is high |
| word_gap | output | 1 | One-cycle strobe for a word-separator interval |
| ivl_err | output | 1 | One-cycle strobe for an interval timeout |

## Verification
Two functions can fall in the same cycle: a pulse decision and the tick that would carry the count past `GAP_MAX`. The bench places a pulse rise 38 clocks after the last one, which with the bench parameters lands detection on exactly that tick. It expects a word gap with no timeout. One clock later the timeout has already fired, and the same pulse must then produce nothing. A blanked pulse that coincides with a tick is also judged, by checking that the count kept advancing. A behavioural model compares every strobe on every clock.

// File: rtl/ppm_cls_pkg.sv
package ppm_cls_pkg;
  typedef enum logic [1:0] {
    IVL_NONE = 2'd0,
    IVL_ZERO = 2'd1,
    IVL_ONE  = 2'd2,
    IVL_GAP  = 2'd3
  } ivl_class_e;
endpackage

// File: rtl/ppm_reset_sync.sv
module ppm_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_ns = chain[STAGES-1];
endmodule

// File: rtl/ppm_edge_sync.sv
module ppm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] stg;
  logic              last;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stg
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= 1'b0;
          else        stg[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= 1'b0;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b0;
    else        last <= stg[STAGES-1];
  end

  assign rise = stg[STAGES-1] & ~last;
endmodule

// File: rtl/ppm_interval_timer.sv
module ppm_interval_timer #(
  parameter int PRESCALE = 2,
  parameter int GAP_MAX  = 60,
  parameter int CW       = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [CW-1:0] cnt,
  output logic          sat,
  output logic          tmo_hit
);
  localparam logic [CW-1:0] SAT_V = CW'(GAP_MAX + 1);
  localparam logic [CW-1:0] MAX_V = CW'(GAP_MAX);

  logic tick;

  generate
    if (PRESCALE <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] LAST_PH = PW'(PRESCALE - 1);
      logic [PW-1:0] phase;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                phase <= '0;
        else if (clr)              phase <= '0;
        else if (phase == LAST_PH) phase <= '0;
        else                       phase <= phase + 1'b1;
      end
      assign tick = (phase == LAST_PH);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= SAT_V;
    else if (clr)                  cnt <= '0;
    else if (tick && cnt != SAT_V) cnt <= cnt + 1'b1;
  end

  assign sat     = (cnt == SAT_V);
  assign tmo_hit = tick && !clr && (cnt == MAX_V);
endmodule

// File: rtl/ppm_band_sort.sv
module ppm_band_sort
  import ppm_cls_pkg::*;
#(
  parameter int BLANK   = 10,
  parameter int ONE_MIN = 16,
  parameter int GAP_MIN = 30,
  parameter int CW      = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse,
  input  logic [CW-1:0] cnt,
  input  logic          sat,
  input  logic          tmo_hit,
  output logic          clr,
  output logic          bit_vld,
  output logic          bit_val,
  output logic          word_gap,
  output logic          ivl_err
);
  localparam logic [CW-1:0] BLANK_V = CW'(BLANK);
  localparam logic [CW-1:0] ONE_V   = CW'(ONE_MIN);
  localparam logic [CW-1:0] GAP_V   = CW'(GAP_MIN);

  ivl_class_e cls;
  logic       accept;

  assign accept = pulse && !sat && (cnt >= BLANK_V);
  assign clr    = pulse && (sat || cnt >= BLANK_V);

  always_comb begin
    if (!accept)           cls = IVL_NONE;
    else if (cnt < ONE_V)  cls = IVL_ZERO;
    else if (cnt < GAP_V)  cls = IVL_ONE;
    else                   cls = IVL_GAP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_vld  <= 1'b0;
      bit_val  <= 1'b0;
      word_gap <= 1'b0;
      ivl_err  <= 1'b0;
    end else begin
      bit_vld  <= (cls == IVL_ZERO) || (cls == IVL_ONE);
      bit_val  <= (cls == IVL_ONE);
      word_gap <= (cls == IVL_GAP);
      ivl_err  <= tmo_hit;
    end
  end
endmodule

// File: rtl/ppm_interval_classifier.sv
module ppm_interval_classifier #(
  parameter int PRESCALE = 2,
  parameter int BLANK    = 10,
  parameter int ONE_MIN  = 16,
  parameter int GAP_MIN  = 30,
  parameter int GAP_MAX  = 60,
  parameter int SYNC_STG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ppm_in,
  output logic bit_vld,
  output logic bit_val,
  output logic word_gap,
  output logic ivl_err
);
  localparam int CW = $clog2(GAP_MAX + 2);

  logic          rst_ns;
  logic          pulse_det;
  logic          clr;
  logic          sat;
  logic          tmo_hit;
  logic [CW-1:0] cnt;

  ppm_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  ppm_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_ns), .din(ppm_in), .rise(pulse_det)
  );

  ppm_interval_timer #(.PRESCALE(PRESCALE), .GAP_MAX(GAP_MAX), .CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_ns), .clr(clr),
    .cnt(cnt), .sat(sat), .tmo_hit(tmo_hit)
  );

  ppm_band_sort #(.BLANK(BLANK), .ONE_MIN(ONE_MIN), .GAP_MIN(GAP_MIN), .CW(CW)) u_sort (
    .clk(clk), .rst_n(rst_ns), .pulse(pulse_det), .cnt(cnt), .sat(sat),
    .tmo_hit(tmo_hit), .clr(clr), .bit_vld(bit_vld), .bit_val(bit_val),
    .word_gap(word_gap), .ivl_err(ivl_err)
  );
endmodule

// File: rtl/ppm_interval_classifier_chk.sv
module ppm_interval_classifier_chk #(
  parameter int BLANK   = 10,
  parameter int GAP_MAX = 60,
  parameter int CW      = 6
) (
  input logic          clk,
  input logic          rst_ns,
  input logic          pulse_det,
  input logic [CW-1:0] cnt,
  input logic          sat,
  input logic          bit_vld,
  input logic          word_gap,
  input logic          ivl_err
);
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0({bit_vld, word_gap, ivl_err}));

  a_r6_err_at_max: assert property (@(posedge clk) disable iff (!rst_ns)
    ivl_err |-> ($past(cnt) == CW'(GAP_MAX) && sat));

  a_r6_sat_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    (sat && !pulse_det) |=> sat);

  a_r2_blank_keeps_count: assert property (@(posedge clk) disable iff (!rst_ns)
    (pulse_det && cnt < CW'(BLANK)) |=> (!bit_vld && !word_gap && cnt >= $past(cnt)));

  a_r3_strobe_cause: assert property (@(posedge clk) disable iff (!rst_ns)
    (bit_vld || word_gap) |-> ($past(pulse_det) && $past(cnt) >= CW'(BLANK)));

  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_ns)
    !pulse_det |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  a_r8_pulse_beats_timeout: assert property (@(posedge clk) disable iff (!rst_ns)
    (pulse_det && cnt == CW'(GAP_MAX)) |=> (word_gap && !ivl_err));
endmodule

bind ppm_interval_classifier ppm_interval_classifier_chk #(
  .BLANK(BLANK), .GAP_MAX(GAP_MAX), .CW(CW)
) u_chk (
  .clk(clk), .rst_ns(rst_ns), .pulse_det(pulse_det), .cnt(cnt), .sat(sat),
  .bit_vld(bit_vld), .word_gap(word_gap), .ivl_err(ivl_err)
);

// File: tb/ppm_interval_classifier_test.sv
`timescale 1ns/1ps
module ppm_interval_classifier_test;
  localparam int P  = 2;
  localparam int BL = 4;
  localparam int OM = 7;
  localparam int GM = 11;
  localparam int GX = 18;
  localparam int SATC = GX + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ppm = 1'b0;
  logic bit_vld, bit_val, word_gap, ivl_err;

  int n_tests = 0;
  int n_fail = 0;
  int n_b0 = 0, n_b1 = 0, n_gp = 0, n_er = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  ppm_interval_classifier #(
    .PRESCALE(P), .BLANK(BL), .ONE_MIN(OM), .GAP_MIN(GM), .GAP_MAX(GX)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ppm_in(ppm), .bit_vld(bit_vld),
    .bit_val(bit_val), .word_gap(word_gap), .ivl_err(ivl_err)
  );

  // behavioural reference
  bit hist[$];
  int m_cnt = SATC;
  int m_ph = 0;
  bit e_bv = 0, e_bval = 0, e_gap = 0, e_err = 0;

  always @(posedge clk) begin
    bit pul;
    if (!rst_n) begin
      hist = {};
      for (int k = 0; k < 3; k++) hist.push_front(1'b0);
      m_cnt = SATC; m_ph = 0;
      e_bv = 0; e_bval = 0; e_gap = 0; e_err = 0;
    end else begin
      pul = hist[1] && !hist[2];
      e_bv = 0; e_bval = 0; e_gap = 0; e_err = 0;
      if (pul && m_cnt == SATC) begin
        m_cnt = 0; m_ph = 0;
      end else if (pul && m_cnt >= BL) begin
        if (m_cnt < OM) begin e_bv = 1; e_bval = 0; end
        else if (m_cnt < GM) begin e_bv = 1; e_bval = 1; end
        else e_gap = 1;
        m_cnt = 0; m_ph = 0;
      end else begin
        if (m_ph == P - 1 && m_cnt < SATC) begin
          if (m_cnt == GX) e_err = 1;
          m_cnt++;
        end
        m_ph = (m_ph + 1) % P;
      end
      hist.push_front(ppm);
      void'(hist.pop_back());
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R3 R4 bit_vld vs model", int'(bit_vld), int'(e_bv));
      if (e_bv) check("R4 bit_val vs model", int'(bit_val), int'(e_bval));
      check("R5 word_gap vs model", int'(word_gap), int'(e_gap));
      check("R6 ivl_err vs model", int'(ivl_err), int'(e_err));
      check("R10 one strobe", int'(bit_vld) + int'(word_gap) + int'(ivl_err) <= 1, 1);
      if (bit_vld && !bit_val) n_b0++;
      if (bit_vld && bit_val) n_b1++;
      if (word_gap) n_gp++;
      if (ivl_err) n_er++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic pw(input int d);
    ppm = 1'b1;
    repeat (2) @(negedge clk);
    ppm = 1'b0;
    repeat (d - 2) @(negedge clk);
  endtask

  task automatic step(input int d, input int b0, input int b1, input int gp,
                      input int er, input string tag);
    int s0, s1, sg, se;
    s0 = n_b0; s1 = n_b1; sg = n_gp; se = n_er;
    pw(d);
    check({tag, " zero count"}, n_b0 - s0, b0);
    check({tag, " one count"}, n_b1 - s1, b1);
    check({tag, " gap count"}, n_gp - sg, gp);
    check({tag, " err count"}, n_er - se, er);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check("R1 reset bit_vld", int'(bit_vld), 0);
    check("R1 reset word_gap", int'(word_gap), 0);
    check("R1 reset ivl_err", int'(ivl_err), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 idle after reset", int'(bit_vld | word_gap | ivl_err), 0);

    step(11, 0, 0, 0, 0, "R1 first pulse");
    step(17, 1, 0, 0, 0, "R3 zero band");
    step(27, 0, 1, 0, 0, "R4 one band");
    step(5,  0, 0, 1, 0, "R5 gap band");
    step(6,  0, 0, 0, 0, "R2 blanked pulse");
    step(9,  1, 0, 0, 0, "R2 count kept");
    step(8,  1, 0, 0, 0, "R7 low edge of zero band");
    step(6,  0, 0, 0, 0, "R7 just inside blanking");
    step(15, 1, 0, 0, 0, "R3 top of zero band");
    step(22, 0, 1, 0, 0, "R4 low edge of one band");
    step(23, 0, 1, 0, 0, "R4 top of one band");
    step(38, 0, 0, 1, 0, "R5 low edge of gap band");
    step(60, 0, 0, 1, 1, "R8 gap on timeout tick");
    step(12, 0, 0, 0, 0, "R6 pulse after timeout");
    step(20, 1, 0, 0, 0, "R6 restart measured");

    begin
      int s1;
      s1 = n_b1;
      ppm = 1'b1;
      repeat (20) @(negedge clk);
      ppm = 1'b0;
      repeat (10) @(negedge clk);
      check("R9 held input one event", n_b1 - s1, 1);
    end
    repeat (60) @(negedge clk);

    pw(11);
    ppm = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 no strobe at 2 clocks", int'(bit_vld), 0);
    @(negedge clk);
    check("R9 strobe at 3 clocks", int'(bit_vld), 1);
    check("R9 strobe value", int'(bit_val), 0);
    ppm = 1'b0;
    repeat (60) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule